// File: doc/BRIEF.md
# Low-power SDRAM deep power-down sequencer

This block sits on the controller side of a low-power SDRAM. It puts the memory into its deep power-down state on request, and it runs the full re-initialisation the memory needs to come back out. On an entry request from the idle state it issues the deep power-down command in the same cycle that clock enable goes low. It then holds clock enable low until an exit request arrives.

On exit the block raises clock enable and holds NOP for a wait time. The wait length comes from a clock-frequency parameter and is rounded up to whole cycles. The block then issues a precharge to all banks. After that come the refresh phase and the register-load phase, in the order chosen by a configuration input. The refresh phase is a programmable number of auto-refresh commands. The register-load phase is a mode-register load followed by an extended mode-register load. Every pair of commands is separated by a parameterised minimum gap. The array loses its contents while powered down. For that reason, the cycle in which the block reports ready again also carries a one-cycle pulse telling the user that all stored data is invalid.

Top module: `lpsdram_dpd_seq`

## Requirements
- R1: Out of reset, cke_o is high and the command pins show NOP (cs_n 0, ras_n 1, cas_n 1, we_n 1). In the same state ready_o is high and both in_dpd_o and data_lost_o are low.
- R2: An entry request while ready produces a single command cycle with cs_n 0, ras_n 1, cas_n 1, we_n 0 and cke_o low in that same cycle. After it, cke_o stays low, in_dpd_o is high and ready_o is low.
- R3: An exit request while powered down raises cke_o with NOP on the pins. The first command follows the rise of cke_o by exactly ceil(WAIT_US * CLK_FREQ_KHZ / 1000) cycles.
- R4: The first command after the wait is a precharge (cs_n 0, ras_n 0, cas_n 1, we_n 0) with address bit 10 set to select every bank.
- R5: The exit sequence contains exactly N_REF auto-refresh commands (cs_n 0, ras_n 0, cas_n 0, we_n 1). Consecutive refreshes are T_RFC cycles apart.
- R6: A mode-register load (all four command pins low) puts mode_val_i on the address and 0 on the bank pins. It is followed T_MRD cycles later by the same command with ext_mode_val_i on the address and 2 on the bank pins (bank bit 1 set).
- R7: refresh_first_i is sampled with the exit request. A value of 1 runs the refreshes before the two loads, and 0 runs the loads first. The first command after the precharge comes T_RP cycles later. A refresh is followed by its next command T_RFC cycles later, and a load by its next command T_MRD cycles later.
- R8: ready_o rises one gap (T_RFC after a final refresh, T_MRD after a final load) after the last command. data_lost_o is high for exactly that one cycle.
- R9: An exit request is ignored unless the block is powered down. An entry request is ignored unless the block is ready.
- R10: Every cycle of the exit sequence that carries no listed command drives NOP. While powered down the pins also show NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_req_i | input | 1 | Request to enter deep power-down |
| exit_req_i | input | 1 | Request to leave deep power-down |
| refresh_first_i | input | 1 | 1: refreshes before register loads |
| mode_val_i | input | AW | Mode-register value |
| ext_mode_val_i | input | AW | Extended mode-register value |
| ready_o | output | 1 | Memory accepts normal commands |
| in_dpd_o | output | 1 | Memory is in deep power-down |
| data_lost_o | output | 1 | One-cycle pulse: contents invalid |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | AW | Address pins |
| ba_o | output | BAW | Bank-address pins |

## Verification
The bench builds the block with a 47 kHz clock parameter against the 200 us wait, which gives a 10-cycle wait. That choice exercises the round-up path. It also sets three refreshes and distinct gaps of 3, 5 and 2 cycles, so a misplaced command or a wrong gap shows up as a wrong cycle number. With those small values, both phase orders across several register values run as full enter/exit cycles within a few hundred clocks. Every command's cycle is predicted arithmetically from the rise of clock enable.

// File: rtl/lpsdram_dpd_pkg.sv
package lpsdram_dpd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTER, ST_DOWN, ST_WAIT, ST_PRE, ST_REF, ST_MRS, ST_EMRS, ST_GAP
  } seq_st_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_DPD, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam int unsigned ALL_BANK_BIT = 10;

  function automatic cmd_pins_t pins_of(cmd_e c);
    cmd_pins_t p;
    unique case (c)
      CMD_DPD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
      CMD_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS,
      CMD_EMRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpsdram_dpd_timer.sv
module lpsdram_dpd_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tmr_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lpsdram_dpd_cmd_enc.sv
module lpsdram_dpd_cmd_enc
  import lpsdram_dpd_pkg::*;
#(
  parameter int AW      = 13,
  parameter int BAW     = 2,
  parameter int EMRS_BA = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  cmd_e           cmd_i,
  input  logic           cke_i,
  input  logic [AW-1:0]  mode_i,
  input  logic [AW-1:0]  ext_mode_i,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [AW-1:0]  addr_o,
  output logic [BAW-1:0] ba_o
);

  cmd_pins_t     pins;
  logic [AW-1:0] addr_d;
  logic [BAW-1:0] ba_d;

  always_comb begin
    pins   = pins_of(cmd_i);
    addr_d = '0;
    ba_d   = '0;
    unique case (cmd_i)
      CMD_PRE:  addr_d[ALL_BANK_BIT] = 1'b1;
      CMD_MRS:  addr_d = mode_i;
      CMD_EMRS: begin addr_d = ext_mode_i; ba_d = BAW'(EMRS_BA); end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o   <= 1'b1;
      cs_n_o  <= 1'b0;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      addr_o  <= '0;
      ba_o    <= '0;
    end else begin
      cke_o   <= cke_i;
      cs_n_o  <= pins.cs_n;
      ras_n_o <= pins.ras_n;
      cas_n_o <= pins.cas_n;
      we_n_o  <= pins.we_n;
      addr_o  <= addr_d;
      ba_o    <= ba_d;
    end
  end

  // R2
  dpd_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> (!cs_n_o && ras_n_o && cas_n_o && !we_n_o));

  // R10
  down_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && !$fell(cke_o)) |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));

endmodule

// File: rtl/lpsdram_dpd_seq.sv
module lpsdram_dpd_seq
  import lpsdram_dpd_pkg::*;
#(
  parameter int CLK_FREQ_KHZ = 125000,
  parameter int WAIT_US      = 200,
  parameter int N_REF        = 2,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 10,
  parameter int T_MRD        = 2,
  parameter int AW           = 13,
  parameter int BAW          = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enter_req_i,
  input  logic           exit_req_i,
  input  logic           refresh_first_i,
  input  logic [AW-1:0]  mode_val_i,
  input  logic [AW-1:0]  ext_mode_val_i,
  output logic           ready_o,
  output logic           in_dpd_o,
  output logic           data_lost_o,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [AW-1:0]  addr_o,
  output logic [BAW-1:0] ba_o
);

  localparam int WAIT_CYC = (WAIT_US * CLK_FREQ_KHZ + 999) / 1000;
  localparam int MAX_CYC  = imax(imax(WAIT_CYC, T_RP), imax(T_RFC, T_MRD));
  localparam int TW       = $clog2(MAX_CYC + 1);
  localparam int RW       = $clog2(N_REF + 1);
  localparam logic [TW-1:0] LD_WAIT = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 2);
  localparam logic [TW-1:0] LD_RFC  = TW'(T_RFC - 2);
  localparam logic [TW-1:0] LD_MRD  = TW'(T_MRD - 2);

  initial begin
    if (T_RP < 2 || T_RFC < 2 || T_MRD < 2 || N_REF < 1 || WAIT_CYC < 1 || AW < 11)
      $error("lpsdram_dpd_seq: illegal parameter set");
  end

  seq_st_e       state_q, state_d, nxt_q, nxt_d;
  logic [RW-1:0] ref_q, ref_d;
  logic          ord_q, ord_d;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  cmd_e          cmd;
  logic          ready_q, in_dpd_q, lost_q;

  lpsdram_dpd_timer #(.TW(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    nxt_d    = nxt_q;
    ref_d    = ref_q;
    ord_d    = ord_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cmd      = CMD_NOP;
    unique case (state_q)
      ST_IDLE:  if (enter_req_i) state_d = ST_ENTER;
      ST_ENTER: begin cmd = CMD_DPD; state_d = ST_DOWN; end
      ST_DOWN: if (exit_req_i) begin
        state_d  = ST_WAIT;
        ord_d    = refresh_first_i;
        ref_d    = '0;
        tmr_load = 1'b1;
        tmr_val  = LD_WAIT;
      end
      ST_WAIT: if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        cmd      = CMD_PRE;
        tmr_load = 1'b1;
        tmr_val  = LD_RP;
        nxt_d    = ord_q ? ST_REF : ST_MRS;
        state_d  = ST_GAP;
      end
      ST_REF: begin
        cmd      = CMD_REF;
        ref_d    = ref_q + 1'b1;
        tmr_load = 1'b1;
        tmr_val  = LD_RFC;
        if (ref_q == RW'(N_REF - 1)) nxt_d = ord_q ? ST_MRS : ST_IDLE;
        else                         nxt_d = ST_REF;
        state_d  = ST_GAP;
      end
      ST_MRS: begin
        cmd      = CMD_MRS;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
        nxt_d    = ST_EMRS;
        state_d  = ST_GAP;
      end
      ST_EMRS: begin
        cmd      = CMD_EMRS;
        tmr_load = 1'b1;
        tmr_val  = LD_MRD;
        nxt_d    = ord_q ? ST_IDLE : ST_REF;
        state_d  = ST_GAP;
      end
      ST_GAP:  if (tmr_zero) state_d = nxt_q;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      ref_q    <= '0;
      ord_q    <= 1'b0;
      ready_q  <= 1'b1;
      in_dpd_q <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      nxt_q    <= nxt_d;
      ref_q    <= ref_d;
      ord_q    <= ord_d;
      // status registered from state_q so it lines up with the pin stage
      ready_q  <= (state_q == ST_IDLE);
      in_dpd_q <= (state_q == ST_ENTER) || (state_q == ST_DOWN);
      lost_q   <= (state_q == ST_IDLE) && !ready_q;
    end
  end

  lpsdram_dpd_cmd_enc #(.AW(AW), .BAW(BAW), .EMRS_BA(2)) u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .cke_i      (!((state_q == ST_ENTER) || (state_q == ST_DOWN))),
    .mode_i     (mode_val_i),
    .ext_mode_i (ext_mode_val_i),
    .cke_o      (cke_o),
    .cs_n_o     (cs_n_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .addr_o     (addr_o),
    .ba_o       (ba_o)
  );

  assign ready_o     = ready_q;
  assign in_dpd_o    = in_dpd_q;
  assign data_lost_o = lost_q;

  // R9
  enter_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_req_i && state_q != ST_IDLE) |=> (state_q != ST_ENTER));

  // R9
  exit_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_req_i && (state_q == ST_IDLE || state_q == ST_ENTER)) |=> (state_q != ST_WAIT));

  // R4
  pre_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |-> ($past(state_q) == ST_WAIT));

  // R5
  ref_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q <= RW'(N_REF));

  // R8
  lost_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_lost_o |-> (ready_o && !$past(ready_o)));

endmodule

// File: tb/tb_lpsdram_dpd_seq.sv
module tb_lpsdram_dpd_seq;
  localparam int FK   = 47;
  localparam int WU   = 200;
  localparam int NR   = 3;
  localparam int TRP  = 3;
  localparam int TRFC = 5;
  localparam int TMRD = 2;
  localparam int AW   = 13;
  localparam int BAW  = 2;
  localparam int WCYC = (WU * FK + 999) / 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enter_req = 1'b0, exit_req = 1'b0, ref_first = 1'b0;
  logic [AW-1:0] mode_val = '0, ext_val = '0;
  logic ready, in_dpd, lost, cke, cs_n, ras_n, cas_n, we_n;
  logic [AW-1:0] addr;
  logic [BAW-1:0] ba;

  always #4 clk = ~clk;

  lpsdram_dpd_seq #(
    .CLK_FREQ_KHZ(FK), .WAIT_US(WU), .N_REF(NR), .T_RP(TRP), .T_RFC(TRFC),
    .T_MRD(TMRD), .AW(AW), .BAW(BAW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .enter_req_i(enter_req), .exit_req_i(exit_req),
    .refresh_first_i(ref_first), .mode_val_i(mode_val), .ext_mode_val_i(ext_val),
    .ready_o(ready), .in_dpd_o(in_dpd), .data_lost_o(lost), .cke_o(cke),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba)
  );

  int vec = 0, bad = 0, cyc = 0;
  int ev_kind [64];
  int ev_cyc  [64];
  int ev_addr [64];
  int ev_ba   [64];
  int ev_n = 0;
  int cke_rise = -1, rdy_rise = -1, lost_n = 0, lost_cyc = -1;
  logic cke_prev = 1'b1, rdy_prev = 1'b1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  // kinds: 0 NOP, 1 DPD, 2 PRE, 3 REF, 4 MRS, 5 EMRS, 6 other
  function automatic int decode();
    logic [3:0] p;
    p = {cs_n, ras_n, cas_n, we_n};
    if (p == 4'b0111) return 0;
    if (p == 4'b0110 && !cke) return 1;
    if (p == 4'b0010) return 2;
    if (p == 4'b0001) return 3;
    if (p == 4'b0000 && ba == 2'd0) return 4;
    if (p == 4'b0000 && ba == 2'd2) return 5;
    return 6;
  endfunction

  always @(negedge clk) begin
    int k;
    cyc++;
    if (rst_ni) begin
      if (cke && !cke_prev) cke_rise = cyc;
      if (ready && !rdy_prev) rdy_rise = cyc;
      if (lost) begin lost_n++; lost_cyc = cyc; end
      k = decode();
      if (k != 0 && ev_n < 64) begin
        ev_kind[ev_n] = k; ev_cyc[ev_n] = cyc;
        ev_addr[ev_n] = int'(addr); ev_ba[ev_n] = int'(ba);
        ev_n++;
      end
    end
    cke_prev = cke;
    rdy_prev = ready;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_enter();
    @(negedge clk) enter_req = 1'b1;
    @(negedge clk) enter_req = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk) exit_req = 1'b1;
    @(negedge clk) exit_req = 1'b0;
  endtask

  function automatic string tag_of(int k);
    case (k)
      2: return "R4 precharge";
      3: return "R5 refresh";
      4, 5: return "R6 register load";
      default: return "R10 command";
    endcase
  endfunction

  task automatic run_cycle(int ord, logic [AW-1:0] mv, logic [AW-1:0] ev);
    int ek [16];
    int ec [16];
    int n, t;
    mode_val = mv;
    ext_val  = ev;
    @(negedge clk);
    ev_n = 0;
    pulse_enter();
    repeat (4) @(negedge clk);
    chk("R2 one entry command", ev_n, 1);
    chk("R2 entry kind", ev_kind[0], 1);
    chk("R2 cke low", int'(cke), 0);
    chk("R2 in_dpd", int'(in_dpd), 1);
    chk("R2 ready low", int'(ready), 0);
    pulse_enter();
    repeat (3) @(negedge clk);
    chk("R9 enter while down ignored", ev_n, 1);
    chk("R9 still down", int'(in_dpd & ~cke), 1);

    ev_n = 0; lost_n = 0; cke_rise = -1; rdy_rise = -1; lost_cyc = -1;
    ref_first = ord[0];
    pulse_exit();
    ref_first = ~ord[0];   // R7: must not matter after sampling
    pulse_enter();         // R9: ignored mid-sequence
    pulse_exit();
    for (int i = 0; i < 500 && !ready; i++) @(negedge clk);
    repeat (3) @(negedge clk);

    n = 0;
    t = cke_rise + WCYC;
    ek[n] = 2; ec[n] = t; n++; t += TRP;
    if (ord != 0) begin
      for (int i = 0; i < NR; i++) begin ek[n] = 3; ec[n] = t; n++; t += TRFC; end
      ek[n] = 4; ec[n] = t; n++; t += TMRD;
      ek[n] = 5; ec[n] = t; n++; t += TMRD;
    end else begin
      ek[n] = 4; ec[n] = t; n++; t += TMRD;
      ek[n] = 5; ec[n] = t; n++; t += TMRD;
      for (int i = 0; i < NR; i++) begin ek[n] = 3; ec[n] = t; n++; t += TRFC; end
    end

    chk("R3 cke rose", int'(cke_rise > 0), 1);
    chk("R10 command count", ev_n, n);
    for (int i = 0; i < n && i < ev_n; i++) begin
      chk({tag_of(ek[i]), " R7 kind"}, ev_kind[i], ek[i]);
      chk({tag_of(ek[i]), " R3 R7 cycle"}, ev_cyc[i], ec[i]);
      if (ek[i] == 2) chk("R4 addr bit 10", (ev_addr[i] >> 10) & 1, 1);
      if (ek[i] == 4) begin
        chk("R6 mode addr", ev_addr[i], int'(mv));
        chk("R6 mode bank", ev_ba[i], 0);
      end
      if (ek[i] == 5) begin
        chk("R6 ext addr", ev_addr[i], int'(ev));
        chk("R6 ext bank", ev_ba[i], 2);
      end
    end
    chk("R8 ready rise", rdy_rise, t);
    chk("R8 lost pulses", lost_n, 1);
    chk("R8 lost cycle", lost_cyc, t);
    chk("R8 in_dpd low", int'(in_dpd), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 cke", int'(cke), 1);
    chk("R1 nop pins", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk("R1 ready", int'(ready), 1);
    chk("R1 in_dpd", int'(in_dpd), 0);
    chk("R1 data_lost", int'(lost), 0);

    ev_n = 0;
    pulse_exit();
    repeat (5) @(negedge clk);
    chk("R9 exit while idle ignored", ev_n, 0);
    chk("R9 ready kept", int'(ready & cke), 1);

    for (int o = 0; o < 2; o++)
      for (int k = 0; k < 3; k++)
        run_cycle(o, AW'(13'h0033 + k * 13'h0521), AW'(13'h1400 ^ (k * 13'h0107)));

    summary();
    $finish;
  end
endmodule